// File: doc/BRIEF.md
# Windowed CCD Clock Sequencer

This block produces the timing that moves charge out of a full-frame image sensor and reads one rectangular window from it. On a start strobe it takes a snapshot of the window parameters. It then runs an optional flush, discards the rows above the window, and shifts window rows into the horizontal register in groups. It clocks each register row past the output node. Rows and pixels outside the window move with the dump gate held or at double speed. Window pixels get a full slot with a sampling strobe for the correlated double sampler and converter.

Binning in the vertical direction stacks several row shifts before one horizontal pass. Binning in the horizontal direction sums pixels on the output node by suppressing the node reset between them. Overclocking adds extra full-speed pixels after each window row and extra rows after the window, so that residual charge can be measured. A stimulus bit alternates with each output pixel and selects a low or a high injected test level. Out-of-range settings are clipped and reported.

The state machine has nine states. IDLE waits for start. FLUSH pulses the dump gate. VSKIP shifts the rows above the window with the dump gate high. VSHIFT shifts one bin group of window rows. HSKIP clocks discarded pixels fast, either before the window origin or in the tail after it. HREAD reads window pixels. HOVER reads overclock pixels. VOVER shifts one overclock row. DONE marks the end of the frame.

The transitions are as follows:
- IDLE→FLUSH on start when the dump count is nonzero.
- IDLE or FLUSH→VSKIP when the row origin is nonzero, otherwise →VSHIFT.
- VSKIP→VSHIFT.
- VSHIFT or VOVER→HSKIP when the column origin is nonzero, otherwise →HREAD.
- HSKIP (leading)→HREAD.
- HREAD→HOVER, →HSKIP (tail) or →row end.
- HOVER→HSKIP (tail) or →row end.
- At row end: →VSHIFT while window rows remain, →VOVER while overclock rows remain, otherwise →DONE.
- DONE→IDLE.

Top module: `ccd_window_seq`

## Requirements
- R1: After reset, and while idle, every output is low: the shift enables, flush_gate, node_reset, sample, stim_bit, row_done, frame_done, busy and cfg_err.
- R2: With dump_cnt = D > 0, a frame starts with D dump-gate pulses. Each pulse is DUMP_CYC cycles high, followed by one low cycle. With D = 0 there is no flush.
- R3: The win_y0 rows above the window are each shifted for VSHIFT_CYC cycles with vshift_en and flush_gate both high.
- R4: Window rows are shifted in groups of vbin. A value of 0 counts as 1, and the last group holds only the rows that remain. Each shift holds vshift_en for VSHIFT_CYC cycles. One horizontal pass follows each group.
- R5: In a horizontal pass, the win_x0 pixels before the window take SKIP_CYC cycles each and window pixels take PIX_CYC cycles each. hshift_en is never high together with vshift_en.
- R6: node_reset is high in the first cycle of every skipped or overclock pixel slot. In a window it is high only on the first pixel of each group of hbin pixels (0 counts as 1).
- R7: sample is high once per binned output pixel, in slot cycle SAMPLE_OFS of the last pixel of the group (or of the last window pixel). It is high once per overclock pixel in that same cycle. It is never high in a skipped slot or together with node_reset.
- R8: After each window row, min(ovr_h, rem) overclock pixels are read at full speed, where rem is the number of register pixels after the window in the half-register. The rest of rem is skipped fast.
- R9: After the last window group, ovr_v overclock rows follow. Each is one VSHIFT_CYC shift followed by a full horizontal pass.
- R10: hshift_en equals port_sel during horizontal clocking: bit 0 is the left port and bit 1 is the right port. A value of 00 is treated as 01.
- R11: A start snapshot is clipped and cfg_err is set when any of these is true: win_x0 ≥ HALF_COLS (clipped to HALF_COLS−1), win_w = 0 (→1), win_x0+win_w > HALF_COLS (width cut to fit), win_h = 0 (→1), win_h > MAX_HEIGHT (→MAX_HEIGHT), or win_y0+height > SENSOR_ROWS (origin lowered). cfg_err keeps its value until the next accepted start.
- R12: stim_bit equals stim_en AND bit 0 of the output-pixel index within the row. The index counts from 0 across window and overclock pixels, and stim_bit is valid whenever sample is high.
- R13: row_done is a one-cycle pulse per horizontal pass, in its last cycle. frame_done is high for one cycle after the last row, and busy is low on the next cycle.
- R14: A start while busy is ignored. The frame in progress keeps its snapshot and timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| win_x0 | input | 12 | Window column origin within the half-register |
| win_w | input | 12 | Window width in pixels |
| win_y0 | input | 11 | Window row origin |
| win_h | input | 11 | Window height in rows |
| vbin | input | 4 | Rows stacked per horizontal pass |
| hbin | input | 4 | Pixels summed per output pixel |
| ovr_h | input | 4 | Overclock pixels per row |
| ovr_v | input | 4 | Overclock rows per frame |
| port_sel | input | 2 | Readout port enables (bit0 left, bit1 right) |
| dump_cnt | input | 4 | Dump-gate pulses before the frame |
| stim_en | input | 1 | Enable the alternating stimulus bit |
| vshift_en | output | 1 | Vertical phase enable |
| hshift_en | output | 2 | Horizontal phase enable per port |
| flush_gate | output | 1 | Dump gate enable |
| node_reset | output | 1 | Output node reset pulse |
| sample | output | 1 | Sampler and converter strobe |
| stim_bit | output | 1 | Stimulus level select |
| row_done | output | 1 | End of a horizontal pass |
| frame_done | output | 1 | End of frame |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last snapshot was clipped |

## Verification
The bench builds the sequencer with a 16-pixel half-register, 32 sensor rows, a height limit of 8, and slots of 8, 4, 6 and 5 cycles for pixel, skip, shift and dump, with the sample at cycle 6. These sizes let whole frames run in a few hundred cycles. They also make the clipping limits, short final bin groups, the tail split between overclocked and skipped pixels, and full-row overclock passes reachable with small window values. Each frame is checked through cycle counts of every enable, pulse counts, the sample offset from the node reset, and the stimulus parity.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    localparam int XW = 12;
    localparam int YW = 11;
    localparam int BW = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FLUSH,
        S_VSKIP,
        S_VSHIFT,
        S_HSKIP,
        S_HREAD,
        S_HOVER,
        S_VOVER,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic [XW-1:0] x0;
        logic [XW-1:0] w;
        logic [XW-1:0] ov;
        logic [XW-1:0] tail;
        logic [YW-1:0] y0;
        logic [YW-1:0] h;
        logic [YW-1:0] ovv;
        logic [BW-1:0] vbin;
        logic [BW-1:0] hbin;
        logic [BW-1:0] dumps;
        logic [1:0]    ports;
        logic          stim;
    } seq_cfg_t;

endpackage

// File: rtl/ccdseq_cfg_clip.sv
module ccdseq_cfg_clip
    import ccdseq_pkg::*;
#(
    parameter int HALF_COLS   = 1024,
    parameter int SENSOR_ROWS = 1024,
    parameter int MAX_HEIGHT  = 512
) (
    input  logic [XW-1:0] req_x0,
    input  logic [XW-1:0] req_w,
    input  logic [YW-1:0] req_y0,
    input  logic [YW-1:0] req_h,
    input  logic [BW-1:0] req_vbin,
    input  logic [BW-1:0] req_hbin,
    input  logic [BW-1:0] req_ovr_h,
    input  logic [BW-1:0] req_ovr_v,
    input  logic [BW-1:0] req_dumps,
    input  logic [1:0]    req_ports,
    input  logic          req_stim,
    output seq_cfg_t      cfg,
    output logic          err
);

    localparam logic [XW:0] HALF_L = (XW+1)'(HALF_COLS);
    localparam logic [YW:0] ROWS_L = (YW+1)'(SENSOR_ROWS);
    localparam logic [YW:0] MAXH_L = (YW+1)'(MAX_HEIGHT);
    localparam logic [XW:0] ONE_X  = (XW+1)'(1);
    localparam logic [YW:0] ONE_Y  = (YW+1)'(1);

    logic [XW:0] x0, w, rem, ovh, ov, tl;
    logic [YW:0] y0, h;

    always_comb begin
        err = 1'b0;
        // column origin must land inside the half-register (R11)
        x0 = {1'b0, req_x0};
        if (x0 >= HALF_L) begin
            x0  = HALF_L - ONE_X;
            err = 1'b1;
        end
        w = {1'b0, req_w};
        if (w == '0) begin
            w   = ONE_X;
            err = 1'b1;
        end
        if (x0 + w > HALF_L) begin
            w   = HALF_L - x0;
            err = 1'b1;
        end
        h = {1'b0, req_h};
        if (h == '0) begin
            h   = ONE_Y;
            err = 1'b1;
        end
        if (h > MAXH_L) begin
            h   = MAXH_L;
            err = 1'b1;
        end
        y0 = {1'b0, req_y0};
        if (y0 + h > ROWS_L) begin
            y0  = ROWS_L - h;
            err = 1'b1;
        end
        // split the register tail into overclocked and fast-skipped pixels (R8)
        rem = HALF_L - x0 - w;
        ovh = {{(XW+1-BW){1'b0}}, req_ovr_h};
        ov  = (ovh < rem) ? ovh : rem;
        tl  = rem - ov;

        cfg.x0    = x0[XW-1:0];
        cfg.w     = w[XW-1:0];
        cfg.ov    = ov[XW-1:0];
        cfg.tail  = tl[XW-1:0];
        cfg.y0    = y0[YW-1:0];
        cfg.h     = h[YW-1:0];
        cfg.ovv   = {{(YW-BW){1'b0}}, req_ovr_v};
        cfg.vbin  = (req_vbin == '0) ? BW'(1) : req_vbin;
        cfg.hbin  = (req_hbin == '0) ? BW'(1) : req_hbin;
        cfg.dumps = req_dumps;
        cfg.ports = (req_ports == 2'b00) ? 2'b01 : req_ports;
        cfg.stim  = req_stim;
    end

    always_comb begin
        a_r11_clip_in_range: assert (
            ({1'b0, cfg.x0} + {1'b0, cfg.w} <= HALF_L) && (cfg.w != '0)
            && ({1'b0, cfg.h} <= MAXH_L) && (cfg.h != '0)
        );
    end

endmodule

// File: rtl/ccdseq_slot.sv
module ccdseq_slot #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] len,
    output logic [TW-1:0] cnt,
    output logic          last
);

    assign last = run && (cnt == len - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end

    // R5: a slot never runs past its programmed length
    a_r5_slot_in_len: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < len));

endmodule

// File: rtl/ccd_window_seq.sv
module ccd_window_seq
    import ccdseq_pkg::*;
#(
    parameter int HALF_COLS   = 1024,
    parameter int SENSOR_ROWS = 1024,
    parameter int MAX_HEIGHT  = 512,
    parameter int PIX_CYC     = 32,
    parameter int SKIP_CYC    = 16,
    parameter int VSHIFT_CYC  = 192,
    parameter int DUMP_CYC    = 160,
    parameter int SAMPLE_OFS  = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [11:0] win_x0,
    input  logic [11:0] win_w,
    input  logic [10:0] win_y0,
    input  logic [10:0] win_h,
    input  logic [3:0]  vbin,
    input  logic [3:0]  hbin,
    input  logic [3:0]  ovr_h,
    input  logic [3:0]  ovr_v,
    input  logic [1:0]  port_sel,
    input  logic [3:0]  dump_cnt,
    input  logic        stim_en,
    output logic        vshift_en,
    output logic [1:0]  hshift_en,
    output logic        flush_gate,
    output logic        node_reset,
    output logic        sample,
    output logic        stim_bit,
    output logic        row_done,
    output logic        frame_done,
    output logic        busy,
    output logic        cfg_err
);

    localparam int TA   = (VSHIFT_CYC > PIX_CYC) ? VSHIFT_CYC : PIX_CYC;
    localparam int TMAX = (TA > DUMP_CYC + 1) ? TA : DUMP_CYC + 1;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_t    state, nxt;
    seq_cfg_t      cfg_d, cfg_q;
    logic          err_d, err_q;
    logic [TW-1:0] slot_len, slot_cnt;
    logic          slot_run, slot_last;
    logic [XW-1:0] ucnt;
    logic [BW-1:0] bcnt;
    logic [YW-1:0] rdone, vov;
    logic          vphase, post;
    logic [XW-1:0] opix;
    logic          unit_end, grp_end, row_end;
    seq_state_t    after_flush, row_first, row_next, after_read, after_over;

    ccdseq_cfg_clip #(
        .HALF_COLS  (HALF_COLS),
        .SENSOR_ROWS(SENSOR_ROWS),
        .MAX_HEIGHT (MAX_HEIGHT)
    ) u_clip (
        .req_x0   (win_x0),
        .req_w    (win_w),
        .req_y0   (win_y0),
        .req_h    (win_h),
        .req_vbin (vbin),
        .req_hbin (hbin),
        .req_ovr_h(ovr_h),
        .req_ovr_v(ovr_v),
        .req_dumps(dump_cnt),
        .req_ports(port_sel),
        .req_stim (stim_en),
        .cfg      (cfg_d),
        .err      (err_d)
    );

    // slot length per state
    always_comb begin
        slot_run = (state != S_IDLE) && (state != S_DONE);
        unique case (state)
            S_FLUSH:                   slot_len = TW'(DUMP_CYC + 1);
            S_VSKIP, S_VSHIFT, S_VOVER: slot_len = TW'(VSHIFT_CYC);
            S_HSKIP:                   slot_len = TW'(SKIP_CYC);
            S_HREAD, S_HOVER:          slot_len = TW'(PIX_CYC);
            default:                   slot_len = TW'(1);
        endcase
    end

    ccdseq_slot #(.TW(TW)) u_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (slot_run),
        .len  (slot_len),
        .cnt  (slot_cnt),
        .last (slot_last)
    );

    // unit and group boundaries
    always_comb begin
        grp_end = (ucnt[BW-1:0] + BW'(1) == cfg_q.vbin)
               || (rdone + YW'(ucnt) + YW'(1) == cfg_q.h);
        unique case (state)
            S_FLUSH:  unit_end = (ucnt + XW'(1) == XW'(cfg_q.dumps));
            S_VSKIP:  unit_end = (ucnt + XW'(1) == XW'(cfg_q.y0));
            S_VSHIFT: unit_end = grp_end;
            S_HSKIP:  unit_end = (ucnt + XW'(1) == (post ? cfg_q.tail : cfg_q.x0));
            S_HREAD:  unit_end = (ucnt + XW'(1) == cfg_q.w);
            S_HOVER:  unit_end = (ucnt + XW'(1) == cfg_q.ov);
            S_VOVER:  unit_end = 1'b1;
            default:  unit_end = 1'b0;
        endcase
        after_flush = (cfg_q.y0 != '0) ? S_VSKIP : S_VSHIFT;
        row_first   = (cfg_q.x0 != '0) ? S_HSKIP : S_HREAD;
        if (vphase) begin
            row_next = (vov < cfg_q.ovv) ? S_VOVER : S_DONE;
        end else if (rdone < cfg_q.h) begin
            row_next = S_VSHIFT;
        end else begin
            row_next = (cfg_q.ovv != '0) ? S_VOVER : S_DONE;
        end
        after_over = (cfg_q.tail != '0) ? S_HSKIP : row_next;
        after_read = (cfg_q.ov != '0) ? S_HOVER : after_over;
        row_end = slot_last && unit_end && (
                     (state == S_HSKIP && post)
                  || (state == S_HREAD && cfg_q.ov == '0 && cfg_q.tail == '0)
                  || (state == S_HOVER && cfg_q.tail == '0));
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (cfg_d.dumps != '0)    nxt = S_FLUSH;
                    else if (cfg_d.y0 != '0)  nxt = S_VSKIP;
                    else                      nxt = S_VSHIFT;
                end
            end
            S_FLUSH:  if (slot_last && unit_end) nxt = after_flush;
            S_VSKIP:  if (slot_last && unit_end) nxt = S_VSHIFT;
            S_VSHIFT: if (slot_last && unit_end) nxt = row_first;
            S_VOVER:  if (slot_last)             nxt = row_first;
            S_HSKIP:  if (slot_last && unit_end) nxt = post ? row_next : S_HREAD;
            S_HREAD:  if (slot_last && unit_end) nxt = after_read;
            S_HOVER:  if (slot_last && unit_end) nxt = after_over;
            S_DONE:                              nxt = S_IDLE;
            default:                             nxt = S_IDLE;
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cfg_q  <= '0;
            err_q  <= 1'b0;
            ucnt   <= '0;
            bcnt   <= '0;
            rdone  <= '0;
            vov    <= '0;
            vphase <= 1'b0;
            post   <= 1'b0;
            opix   <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                cfg_q  <= cfg_d;
                err_q  <= err_d;
                ucnt   <= '0;
                bcnt   <= '0;
                rdone  <= '0;
                vov    <= '0;
                vphase <= 1'b0;
            end else if (slot_last) begin
                ucnt <= unit_end ? '0 : ucnt + XW'(1);
                if (state == S_VSHIFT && unit_end) rdone <= rdone + YW'(ucnt) + YW'(1);
                if (state == S_VOVER)              vov   <= vov + YW'(1);
                if (nxt == S_VOVER)                vphase <= 1'b1;
                if (nxt == S_HSKIP && state != S_HSKIP)
                    post <= (state == S_HREAD) || (state == S_HOVER);
                if (state == S_HREAD)
                    bcnt <= (bcnt + BW'(1) == cfg_q.hbin || unit_end) ? '0 : bcnt + BW'(1);
            end
            if (state == S_VSHIFT || state == S_VOVER) opix <= '0;
            else if (sample)                           opix <= opix + XW'(1);
        end
    end

    // outputs
    always_comb begin
        vshift_en  = (state == S_VSKIP) || (state == S_VSHIFT) || (state == S_VOVER);
        flush_gate = (state == S_FLUSH && slot_cnt < TW'(DUMP_CYC)) || (state == S_VSKIP);
        hshift_en  = (state == S_HSKIP || state == S_HREAD || state == S_HOVER)
                   ? cfg_q.ports : 2'b00;
        node_reset = (slot_cnt == '0) && ((state == S_HSKIP) || (state == S_HOVER)
                   || (state == S_HREAD && bcnt == '0));
        sample     = (slot_cnt == TW'(SAMPLE_OFS)) && ((state == S_HOVER)
                   || (state == S_HREAD && (bcnt + BW'(1) == cfg_q.hbin
                                            || ucnt + XW'(1) == cfg_q.w)));
        stim_bit   = cfg_q.stim && opix[0] && (state == S_HREAD || state == S_HOVER);
        row_done   = row_end;
        frame_done = (state == S_DONE);
        busy       = (state != S_IDLE);
        cfg_err    = err_q;
    end

    // run length of the dump gate, for the width check
    logic [TW-1:0] dhi;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          dhi <= '0;
        else if (!flush_gate) dhi <= '0;
        else if (dhi != TW'(DUMP_CYC)) dhi <= dhi + TW'(1);
    end

    a_r2_dump_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_gate) |-> (dhi >= TW'(DUMP_CYC)));

    a_r5_no_vh_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(vshift_en && (hshift_en != 2'b00)));

    a_r7_no_reset_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !node_reset && (hshift_en != 2'b00));

    a_r13_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !busy);

    a_r14_err_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_err));

endmodule

// File: tb/ccd_window_seq_bench.sv
module ccd_window_seq_bench;

    localparam int HALF = 16;
    localparam int ROWS = 32;
    localparam int MAXH = 8;
    localparam int PX   = 8;
    localparam int SK   = 4;
    localparam int VS   = 6;
    localparam int DMP  = 5;
    localparam int SOFS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] win_x0 = '0, win_w = '0;
    logic [10:0] win_y0 = '0, win_h = '0;
    logic [3:0]  vbin = '0, hbin = '0, ovr_h = '0, ovr_v = '0, dump_cnt = '0;
    logic [1:0]  port_sel = '0;
    logic        stim_en = 1'b0;
    logic        vshift_en, flush_gate, node_reset, sample, stim_bit;
    logic        row_done, frame_done, busy, cfg_err;
    logic [1:0]  hshift_en;

    always #4 clk = ~clk;

    ccd_window_seq #(
        .HALF_COLS(HALF), .SENSOR_ROWS(ROWS), .MAX_HEIGHT(MAXH),
        .PIX_CYC(PX), .SKIP_CYC(SK), .VSHIFT_CYC(VS),
        .DUMP_CYC(DMP), .SAMPLE_OFS(SOFS)
    ) u_ccd_window_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .win_x0(win_x0), .win_w(win_w), .win_y0(win_y0), .win_h(win_h),
        .vbin(vbin), .hbin(hbin), .ovr_h(ovr_h), .ovr_v(ovr_v),
        .port_sel(port_sel), .dump_cnt(dump_cnt), .stim_en(stim_en),
        .vshift_en(vshift_en), .hshift_en(hshift_en), .flush_gate(flush_gate),
        .node_reset(node_reset), .sample(sample), .stim_bit(stim_bit),
        .row_done(row_done), .frame_done(frame_done), .busy(busy), .cfg_err(cfg_err)
    );

    int nchk = 0, nerr = 0;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // port monitor
    bit mon_on = 0, seen_done = 0, want_stim = 0, ofs_chk = 0;
    int n_busy, n_samp, n_rst, n_v, n_dump, n_dedge, n_h0, n_h1, n_row, n_frame;
    int n_stim_bad, n_ofs_bad, since, pidx;
    bit prev_dump;

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) n_busy++;
            if (vshift_en) n_v++;
            if (flush_gate) n_dump++;
            if (flush_gate && !prev_dump) n_dedge++;
            if (hshift_en[0]) n_h0++;
            if (hshift_en[1]) n_h1++;
            if (node_reset) begin n_rst++; since = 0; end
            else since++;
            if (sample) begin
                n_samp++;
                if (stim_bit != (want_stim && pidx[0])) n_stim_bad++;
                if (ofs_chk && since != SOFS) n_ofs_bad++;
                pidx++;
            end
            if (row_done) begin n_row++; pidx = 0; end
            if (frame_done) begin n_frame++; seen_done = 1; end
            prev_dump = flush_gate;
        end
    end

    int last_samples;

    task automatic run_frame(input int x0, w, y0, h, vb, hb, oh, ov, ps, dc, st,
                             input bit ochk, input bit mid);
        int e, x0e, we, he, y0e, vbe, hbe, rem, ovx, tl, pse, g, outs, hrow;
        e = 0;
        x0e = x0; if (x0e >= HALF) begin x0e = HALF - 1; e = 1; end
        we = w;   if (we == 0) begin we = 1; e = 1; end
        if (x0e + we > HALF) begin we = HALF - x0e; e = 1; end
        he = h;   if (he == 0) begin he = 1; e = 1; end
        if (he > MAXH) begin he = MAXH; e = 1; end
        y0e = y0; if (y0e + he > ROWS) begin y0e = ROWS - he; e = 1; end
        vbe = (vb == 0) ? 1 : vb;
        hbe = (hb == 0) ? 1 : hb;
        rem = HALF - x0e - we;
        ovx = (oh < rem) ? oh : rem;
        tl  = rem - ovx;
        pse = (ps == 0) ? 1 : ps;
        g    = (he + vbe - 1) / vbe + ov;
        outs = (we + hbe - 1) / hbe + ovx;
        hrow = x0e * SK + we * PX + ovx * PX + tl * SK;

        n_busy = 0; n_samp = 0; n_rst = 0; n_v = 0; n_dump = 0; n_dedge = 0;
        n_h0 = 0; n_h1 = 0; n_row = 0; n_frame = 0; n_stim_bad = 0; n_ofs_bad = 0;
        since = 0; pidx = 0; prev_dump = 0; seen_done = 0;
        want_stim = (st != 0); ofs_chk = ochk;

        @(negedge clk);
        win_x0 = 12'(x0); win_w = 12'(w); win_y0 = 11'(y0); win_h = 11'(h);
        vbin = 4'(vb); hbin = 4'(hb); ovr_h = 4'(oh); ovr_v = 4'(ov);
        port_sel = 2'(ps); dump_cnt = 4'(dc); stim_en = (st != 0);
        start = 1'b1; mon_on = 1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 20000 && !seen_done; t++) begin
            @(negedge clk);
            if (mid && t == 30) begin
                start = 1'b1; win_h = 11'd1; dump_cnt = 4'd7;   // R14 mid-frame start
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        repeat (2) @(negedge clk);
        mon_on = 0;
        chk("R13 frame completes (watchdog)", int'(seen_done), 1);
        chk("R13 frame_done pulses", n_frame, 1);
        chk("R13 row_done pulses", n_row, g);
        chk("R13 busy idle after frame", int'(busy), 0);
        chk("R5 busy cycles", n_busy, dc * (DMP + 1) + VS * (y0e + he + ov) + g * hrow + 1);
        chk("R4 vshift cycles", n_v, VS * (y0e + he + ov));
        chk("R3 dump gate cycles", n_dump, DMP * dc + VS * y0e);
        chk("R2 dump gate pulses", n_dedge, dc + ((y0e > 0) ? 1 : 0));
        chk("R7 sample count", n_samp, g * outs);
        chk("R6 node reset count", n_rst, g * (x0e + (we + hbe - 1) / hbe + ovx + tl));
        chk("R10 left port cycles", n_h0, pse[0] ? g * hrow : 0);
        chk("R10 right port cycles", n_h1, pse[1] ? g * hrow : 0);
        chk("R12 stimulus parity errors", n_stim_bad, 0);
        if (ochk) chk("R7 sample offset errors", n_ofs_bad, 0);
        chk("R11 cfg_err", int'(cfg_err), e);
        last_samples = n_samp;
    endtask

    task automatic t_reset;
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 vshift idle", int'(vshift_en), 0);
        chk("R1 hshift idle", int'(hshift_en), 0);
        chk("R1 flush idle", int'(flush_gate), 0);
        chk("R1 reset/sample idle", int'(node_reset | sample | stim_bit), 0);
        chk("R1 flags idle", int'(row_done | frame_done | busy | cfg_err), 0);
    endtask

    task automatic t_basic;     // R5 plain window, left port
        run_frame(2, 4, 1, 2, 1, 1, 0, 0, 1, 0, 0, 1, 0);
    endtask

    task automatic t_flush;     // R2 three dumps, no skipped rows
        run_frame(0, 3, 0, 1, 1, 1, 0, 0, 2, 3, 0, 1, 0);
        chk("R2 three flush pulses", n_dedge, 3);
    endtask

    task automatic t_binning;   // R4 R6 short last groups, both ports
        run_frame(1, 7, 2, 5, 3, 3, 0, 0, 3, 1, 1, 0, 0);
        chk("R6 binned samples 2 rows x 3 pixels", last_samples, 6);
    endtask

    task automatic t_overclock; // R8 R9: rem=9 -> 2 overclocked, 7 skipped; 1 extra row
        run_frame(3, 4, 0, 2, 1, 1, 2, 1, 2, 0, 1, 1, 0);
        chk("R8 samples include overclock", last_samples, 18);
        chk("R9 rows include overclock row", n_row, 3);
    endtask

    task automatic t_clip;      // R11 width, height and origin clipped, port 00 -> left
        run_frame(12, 10, 30, 12, 1, 1, 0, 0, 0, 0, 1, 1, 0);
        chk("R11 clipped 8 rows x 4 pixels", last_samples, 32);
    endtask

    task automatic t_busy_start; // R14 start while busy ignored
        run_frame(2, 4, 1, 2, 1, 1, 0, 0, 1, 0, 0, 1, 1);
        chk("R14 sample count unchanged", last_samples, 8);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_flush();
        t_binning();
        t_overclock();
        t_clip();
        t_busy_start();
        t_basic();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #1000000;
        nchk++; nerr++;
        $display("FAIL R13 watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule